// File: doc/BRIEF.md
# Two-Stage Prefetching Instruction Pipeline

This block is a small accumulator-style processor front end with two overlapped stages. Fetch reads the next instruction word from memory while execute works on the current one. There is one single-port synchronous memory, and fetch and execute share it. A load or a store therefore takes the port away from fetch for one cycle, and every instruction behind it slips by that cycle. A taken jump or branch throws away the word that was fetched in the same cycle. It also points the program counter at the target.

Memory has registered reads. A word requested in one cycle is on `mem_rdata` in the next cycle. Execute works directly on that returned word, and also copies it into its own instruction register. Multi-cycle instructions use that copy. The retire strobe pulses once for each completed instruction and carries that instruction's address. `stall` marks a cycle in which fetch was denied the port. `flush` marks a cycle in which the prefetched word was discarded.

The execute controller has three states:
- `S_FILL`: no valid word is on the memory output. Only a fetch happens. Reset enters this state, and so does a taken branch.
- `S_EXEC`: the returned word is decoded and executed, or begins executing.
- `S_MEMWAIT`: the second cycle of a load or store.

Its transitions are:
- fill→exec: always.
- exec→memwait: on a load or store.
- exec→fill: on a taken jump or branch.
- exec→exec: otherwise.
- memwait→exec: always.

Top module: `prefetch_pipe`

## Requirements
- R1: During reset and in the first cycle after it, the port reads address 0 (`mem_en`=1, `mem_we`=0). In that cycle nothing retires, `stall` and `flush` are low, and the accumulator is 0.
- R2: With no memory instructions and no taken branches, instruction k (counting from 0) retires in cycle k+1 after reset. So n instructions finish within 2+(n-1) cycles.
- R3: In the cycle a non-memory instruction retires, the port reads the address that follows that instruction.
- R4: A load (opcode 3) or a store (opcode 4) uses the low 8 operand bits as its data address. It owns the port in its first execute cycle, with `mem_we`=1 and `mem_wdata`=accumulator for a store. In that cycle `stall` is high and nothing retires. It retires in the next cycle, and a load writes the returned word into the accumulator.
- R5: A taken jump or branch raises `flush` in its retire cycle. The word fetched in that cycle is never executed. The next cycle fetches the target, and no instruction retires in that cycle.
- R6: A branch that is not taken costs no cycle.
- R7: `retire_pc` carries the address of the instruction that retires.
- R8: An instruction word holds the opcode in bits 15:12 and a 12-bit operand in bits 11:0. The opcodes are:
  - 0: no operation.
  - 1: load the sign-extended operand into the accumulator.
  - 2: add the sign-extended operand to the accumulator.
  - 5: jump to the low 8 operand bits.
  - 6: branch if the accumulator is zero.
  - 7: branch if the accumulator is non-zero.
- R9: Opcodes 8 to 15 retire like a no operation and leave the accumulator and the flow unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_en | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | 8 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| retire_valid | output | 1 | One instruction completes this cycle |
| retire_pc | output | 8 | Address of the completing instruction |
| acc_out | output | 16 | Accumulator value |
| stall | output | 1 | Fetch denied the port this cycle |
| flush | output | 1 | Prefetched word discarded this cycle |

## Verification
The assertions assume a memory that returns read data in the cycle after the request and holds it until the next read. They also assume that data never depends on the write of the same cycle. The bench's memory model behaves exactly this way, and no program writes into its own code area. With those inputs, the checks can tie stall and flush cycles to retire timing without modelling the data.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam logic [3:0] OPC_NOP  = 4'd0;
    localparam logic [3:0] OPC_LDI  = 4'd1;
    localparam logic [3:0] OPC_ADDI = 4'd2;
    localparam logic [3:0] OPC_LD   = 4'd3;
    localparam logic [3:0] OPC_ST   = 4'd4;
    localparam logic [3:0] OPC_JMP  = 4'd5;
    localparam logic [3:0] OPC_BZ   = 4'd6;
    localparam logic [3:0] OPC_BNZ  = 4'd7;

    typedef enum logic [1:0] {
        S_FILL    = 2'd0,
        S_EXEC    = 2'd1,
        S_MEMWAIT = 2'd2
    } pipe_state_e;

    typedef struct packed {
        logic ld;
        logic st;
        logic ldi;
        logic addi;
        logic jmp;
        logic bz;
        logic bnz;
    } dec_t;

    function automatic dec_t decode_op(input logic [3:0] code);
        dec_t d;
        d = '0;
        case (code)
            OPC_LD:   d.ld   = 1'b1;
            OPC_ST:   d.st   = 1'b1;
            OPC_LDI:  d.ldi  = 1'b1;
            OPC_ADDI: d.addi = 1'b1;
            OPC_JMP:  d.jmp  = 1'b1;
            OPC_BZ:   d.bz   = 1'b1;
            OPC_BNZ:  d.bnz  = 1'b1;
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pp_fetch.sv
module pp_fetch #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              f_gnt,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_pc,
    output logic [ADDR_W-1:0] f_addr,
    output logic [ADDR_W-1:0] tag_pc
);
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] tag_q;

    // pc_q: next address to fetch; tag_q: address of word now on the memory output
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            tag_q <= '0;
        end else begin
            if (f_gnt) begin
                tag_q <= pc_q;
            end
            if (redirect) begin
                pc_q <= redirect_pc;
            end else if (f_gnt) begin
                pc_q <= pc_q + PC_STEP;
            end
        end
    end

    assign f_addr = pc_q;
    assign tag_pc = tag_q;

    AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (f_addr == $past(redirect_pc)));  // R5

endmodule

// File: rtl/pp_arb.sv
module pp_arb #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] f_addr,
    input  logic              ex_req,
    input  logic              ex_we,
    input  logic [ADDR_W-1:0] ex_addr,
    input  logic [DATA_W-1:0] ex_wdata,
    output logic              f_gnt,
    output logic              stall,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    // Fetch wants the port every cycle; execute has priority.
    always_comb begin
        f_gnt     = !ex_req;
        stall     = ex_req;
        mem_en    = 1'b1;
        mem_we    = ex_req && ex_we;
        mem_addr  = ex_req ? ex_addr : f_addr;
        mem_wdata = ex_wdata;
    end

    AST_STALL_NOT_REPEATED: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);  // R4

endmodule

// File: rtl/pp_exec.sv
module pp_exec
    import pp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] tag_pc,
    output logic              ex_req,
    output logic              ex_we,
    output logic [ADDR_W-1:0] ex_addr,
    output logic [DATA_W-1:0] ex_wdata,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              retire,
    output logic [ADDR_W-1:0] retire_pc,
    output logic [DATA_W-1:0] acc
);
    localparam int OPF_W = 4;
    localparam int IMM_W = DATA_W - OPF_W;

    pipe_state_e       state_q, state_d;
    logic [DATA_W-1:0] ir_q;
    logic [ADDR_W-1:0] ir_pc_q;
    logic [DATA_W-1:0] acc_q;

    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] imm_sx;
    logic [ADDR_W-1:0] opnd_addr;
    dec_t              dec;
    logic              is_mem;
    logic              taken;

    // Instruction word: returned memory word in EXEC, held copy in MEMWAIT
    always_comb begin
        word      = (state_q == S_MEMWAIT) ? ir_q : rdata;
        dec       = decode_op(word[DATA_W-1 -: OPF_W]);
        imm_sx    = {{OPF_W{word[IMM_W-1]}}, word[IMM_W-1:0]};
        opnd_addr = word[ADDR_W-1:0];
        is_mem    = dec.ld || dec.st;
        taken     = (state_q == S_EXEC) &&
                    (dec.jmp || (dec.bz && (acc_q == '0)) ||
                     (dec.bnz && (acc_q != '0)));
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FILL:    state_d = S_EXEC;
            S_EXEC: begin
                if (is_mem) begin
                    state_d = S_MEMWAIT;
                end else if (taken) begin
                    state_d = S_FILL;
                end else begin
                    state_d = S_EXEC;
                end
            end
            S_MEMWAIT: state_d = S_EXEC;
            default:   state_d = S_FILL;
        endcase
    end

    // Outputs
    always_comb begin
        ex_req      = 1'b0;
        ex_we       = 1'b0;
        ex_addr     = opnd_addr;
        ex_wdata    = acc_q;
        redirect    = 1'b0;
        redirect_pc = opnd_addr;
        retire      = 1'b0;
        retire_pc   = tag_pc;
        unique case (state_q)
            S_FILL: begin
                retire = 1'b0;
            end
            S_EXEC: begin
                ex_req   = is_mem;
                ex_we    = dec.st;
                retire   = !is_mem;
                redirect = taken;
            end
            S_MEMWAIT: begin
                retire    = 1'b1;
                retire_pc = ir_pc_q;
            end
            default: begin
                retire = 1'b0;
            end
        endcase
    end

    // Datapath: instruction copy and accumulator
    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q    <= '0;
            ir_pc_q <= '0;
            acc_q   <= '0;
        end else begin
            if (state_q == S_EXEC) begin
                ir_q    <= rdata;
                ir_pc_q <= tag_pc;
                if (dec.ldi) begin
                    acc_q <= imm_sx;
                end else if (dec.addi) begin
                    acc_q <= acc_q + imm_sx;
                end
            end else if ((state_q == S_MEMWAIT) && dec.ld) begin
                acc_q <= rdata;
            end
        end
    end

    assign acc = acc_q;

    AST_MEM_RETIRES_NEXT: assert property (@(posedge clk) disable iff (rst)
        ex_req |=> retire);  // R4
    AST_FLUSH_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !retire);  // R5

endmodule

// File: rtl/prefetch_pipe.sv
module prefetch_pipe #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              retire_valid,
    output logic [ADDR_W-1:0] retire_pc,
    output logic [DATA_W-1:0] acc_out,
    output logic              stall,
    output logic              flush
);
    logic              f_gnt;
    logic [ADDR_W-1:0] f_addr;
    logic [ADDR_W-1:0] tag_pc;
    logic              ex_req;
    logic              ex_we;
    logic [ADDR_W-1:0] ex_addr;
    logic [DATA_W-1:0] ex_wdata;
    logic              redirect;
    logic [ADDR_W-1:0] redirect_pc;

    pp_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .f_gnt       (f_gnt),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .f_addr      (f_addr),
        .tag_pc      (tag_pc)
    );

    pp_arb #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .f_addr    (f_addr),
        .ex_req    (ex_req),
        .ex_we     (ex_we),
        .ex_addr   (ex_addr),
        .ex_wdata  (ex_wdata),
        .f_gnt     (f_gnt),
        .stall     (stall),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    pp_exec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_exec (
        .clk         (clk),
        .rst         (rst),
        .rdata       (mem_rdata),
        .tag_pc      (tag_pc),
        .ex_req      (ex_req),
        .ex_we       (ex_we),
        .ex_addr     (ex_addr),
        .ex_wdata    (ex_wdata),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .retire      (retire_valid),
        .retire_pc   (retire_pc),
        .acc         (acc_out)
    );

    assign flush = redirect;

    AST_STALL_NO_RETIRE: assert property (@(posedge clk) disable iff (rst)
        stall |-> !retire_valid);  // R4
    AST_FLUSH_ON_RETIRE: assert property (@(posedge clk) disable iff (rst)
        flush |-> retire_valid);  // R5
    AST_NO_STALL_AND_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !(stall && flush));  // R4

endmodule

// File: tb/sim_prefetch_pipe.sv
module sim_prefetch_pipe;
    localparam logic [3:0] K_LDI = 4'd1, K_ADDI = 4'd2, K_LD = 4'd3, K_ST = 4'd4;
    localparam logic [3:0] K_JMP = 4'd5, K_BZ = 4'd6, K_BNZ = 4'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_en, mem_we, retire_valid, stall, flush;
    logic [7:0]  mem_addr, retire_pc;
    logic [15:0] mem_wdata, acc_out;
    logic [15:0] rdata_q = '0;
    logic [15:0] mem [0:255];
    logic [15:0] ref_mem [0:255];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    prefetch_pipe u0 (
        .clk(clk), .rst(rst), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rdata_q),
        .retire_valid(retire_valid), .retire_pc(retire_pc), .acc_out(acc_out),
        .stall(stall), .flush(flush)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        rdata_q <= mem[mem_addr];
        end
    end

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [11:0] imm);
        return {op, imm};
    endfunction
    function automatic bit is_mem(input logic [15:0] w);
        return (w[15:12] == K_LD) || (w[15:12] == K_ST);
    endfunction
    function automatic bit is_taken(input logic [15:0] w, input logic [15:0] a);
        return (w[15:12] == K_JMP) || (w[15:12] == K_BZ && a == 0) ||
               (w[15:12] == K_BNZ && a != 0);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i] = '0;
            ref_mem[i] = '0;
        end
    endtask

    task automatic put(input int a, input logic [15:0] w);
        mem[a] = w;
        ref_mem[a] = w;
    endtask

    task automatic run_prog(input int ncyc, input int at_cyc, input int at_cnt);
        logic [7:0]  rpc;
        logic [15:0] racc, w, sx;
        int e, r, fill_cyc, nret;
        bit tk, exp_ret, last_unused;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        rpc = 0; racc = 0; e = 1; fill_cyc = -1; nret = 0; last_unused = 0;
        r = e + (is_mem(ref_mem[0]) ? 1 : 0);
        for (int cyc = 0; cyc < ncyc; cyc++) begin
            @(negedge clk);
            w = ref_mem[rpc];
            tk = is_taken(w, racc);
            exp_ret = (cyc == r);
            if (cyc == 0) begin
                chk(mem_en && !mem_we && mem_addr == 0, "R1", "first fetch addr", mem_addr, 0);
                chk(acc_out == 0, "R1", "acc after reset", acc_out, 0);
            end
            chk(retire_valid == exp_ret, "R2", "retire_valid", retire_valid, exp_ret);
            chk(stall == (is_mem(w) && cyc == e), "R4", "stall", stall, is_mem(w) && cyc == e);
            chk(flush == (exp_ret && tk), "R5", "flush", flush, exp_ret && tk);
            chk(acc_out == racc, last_unused ? "R9" : "R8", "acc", acc_out, racc);
            if (is_mem(w) && cyc == e) begin
                chk(mem_addr == w[7:0], "R4", "data addr", mem_addr, w[7:0]);
                chk(mem_we == (w[15:12] == K_ST), "R4", "mem_we", mem_we, w[15:12] == K_ST);
                if (w[15:12] == K_ST) chk(mem_wdata == racc, "R4", "store data", mem_wdata, racc);
            end
            if (exp_ret && !is_mem(w))
                chk(mem_en && !mem_we && mem_addr == rpc + 8'd1, "R3", "overlapped fetch",
                    mem_addr, rpc + 8'd1);
            if (cyc == fill_cyc)
                chk(mem_en && !mem_we && mem_addr == rpc, "R5", "target fetch", mem_addr, rpc);
            if (retire_valid) nret++;
            if (cyc == at_cyc) chk(nret == at_cnt, "R2", "retired count", nret, at_cnt);
            if (exp_ret) begin
                chk(retire_pc == rpc, "R7", "retire_pc", retire_pc, rpc);
                sx = {{4{w[11]}}, w[11:0]};
                last_unused = (w[15:12] >= 4'd8);
                case (w[15:12])
                    K_LDI:  racc = sx;
                    K_ADDI: racc = racc + sx;
                    K_LD:   racc = ref_mem[w[7:0]];
                    K_ST:   ref_mem[w[7:0]] = racc;
                    default: ;
                endcase
                e = r + 1 + (tk ? 1 : 0);
                fill_cyc = tk ? r + 1 : -1;
                rpc = tk ? w[7:0] : rpc + 8'd1;
                r = e + (is_mem(ref_mem[rpc]) ? 1 : 0);
            end
            if (cyc == 0) rst = 1'b0;
        end
        begin
            int bad;
            bad = -1;
            for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i] && bad < 0) bad = i;
            chk(bad < 0, "R4", "memory contents at first mismatch",
                bad < 0 ? 0 : mem[bad], bad < 0 ? 0 : ref_mem[bad]);
        end
    endtask

    initial begin
        // straight line, no hazards (R2, R3, R8)
        clear_mem();
        put(0, mk(K_LDI, 12'd5));    put(1, mk(K_ADDI, 12'd3));
        put(2, mk(K_ADDI, 12'hFFE)); put(3, 16'h0000);
        put(4, mk(K_LDI, 12'h7FF));  put(5, mk(K_ADDI, 12'd1));
        put(6, mk(K_JMP, 12'd6));
        run_prog(30, 6, 6);
        // loads and stores (R4)
        clear_mem();
        put(8'h40, 16'h1234); put(8'h41, 16'h00FF);
        put(0, mk(K_LD, 12'h40)); put(1, mk(K_LD, 12'h41));
        put(2, mk(K_ST, 12'h42)); put(3, mk(K_ADDI, 12'd1));
        put(4, mk(K_ST, 12'h43)); put(5, mk(K_LD, 12'h42));
        put(6, mk(K_JMP, 12'd6));
        run_prog(40, 2, 1);
        // branches taken and not taken (R5, R6)
        clear_mem();
        put(0, mk(K_LDI, 12'd3)); put(1, mk(K_ADDI, 12'hFFF));
        put(2, mk(K_BNZ, 12'd1)); put(3, mk(K_BZ, 12'd6));
        put(4, mk(K_LDI, 12'h055)); put(5, 16'h0000);
        put(6, mk(K_BZ, 12'd7));  put(7, mk(K_LDI, 12'd1));
        put(8, mk(K_BZ, 12'h20)); put(9, mk(K_BNZ, 12'd10));
        put(10, mk(K_ST, 12'h50)); put(11, mk(K_JMP, 12'd11));
        run_prog(60, 0, 0);
        // unused opcodes, jump onto a memory instruction (R9, R5)
        clear_mem();
        put(0, mk(K_LDI, 12'd9)); put(1, 16'h9ABC); put(2, 16'hF000);
        put(3, mk(K_JMP, 12'd5)); put(4, mk(K_ST, 12'h60));
        put(5, mk(K_LD, 12'h30)); put(6, mk(K_BZ, 12'd8));
        put(7, mk(K_LDI, 12'h077)); put(8, mk(K_ST, 12'h61));
        put(9, mk(K_JMP, 12'd9));
        run_prog(50, 3, 3);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule